// File: doc/BRIEF.md
# CAN Bit Timing Synchronizer

This block derives the bit clock for a CAN controller from the system clock. A programmable prescaler turns the clock into time quanta. Each bit is built from quanta in a fixed order: one sync quantum, a propagation stretch, phase segment 1 and then phase segment 2. The block strobes the start of every bit, so transmit logic knows when to change its output. It strobes the sample point at the end of phase segment 1 and presents the bus value taken there.

The block keeps that bit clock locked to falling edges on the bus, which are recessive-to-dominant transitions. While the bus is idle, a falling edge restarts the bit outright. Inside a frame, an edge that arrives late stretches phase segment 1, and an edge that arrives early cuts phase segment 2 short. Each correction is capped at the programmed jump width and lasts for one bit only. Frame decoding, destuffing, arbitration, CRC and error handling belong to the logic around this block.

Top module: `can_bt_sync`

## Requirements
- R1: The quantum tick `tq_tick_o` pulses for one clock once every `brp_i`+1 system clocks, so the encoding 0..63 selects a divisor of 1..64.
- R2: With no edges, one bit lasts 1+`prop_i`+`ps1_i`+`ps2_i` quanta. `bit_start_o` pulses on the tick that opens the sync quantum, which is quantum index 0. `sample_o` pulses 1+`prop_i`+`ps1_i` ticks later, and `rx_bit_o` then holds the synchronized bus value taken at that tick.
- R3: A rising (dominant-to-recessive) transition never alters the timing. A falling edge attributed to quantum index 0 also causes no adjustment. An edge is attributed to the quantum in which it leaves the two-flop input synchronizer.
- R4: With `idle_i` high, a falling edge attributed to any quantum performs a hard sync: that quantum is taken as the sync quantum, and `bit_start_o` pulses on the tick that ends it. The next sample follows `prop_i`+`ps1_i` ticks after that pulse, and the next bit start follows `prop_i`+`ps1_i`+`ps2_i` ticks after it.
- R5: During a frame (`idle_i` low), a falling edge in quantum index q, with 1 ≤ q ≤ `prop_i`+`ps1_i`, lengthens phase segment 1 by min(q, `sjw_i`) quanta. This delays both the sample point and the end of the bit.
- R6: During a frame, a falling edge in phase segment 2 has the error e = N − q, where N is the nominal bit length and q the quantum index. If e ≤ `sjw_i`, the edge quantum becomes the sync quantum, as in R4. Otherwise phase segment 2 is shortened by `sjw_i` quanta, and the next bit begins as soon as the shortened segment ends.
- R7: A lengthening or shortening applies to the current bit only. The bit that follows uses the programmed lengths again.
- R8: Only one synchronization takes effect between two sample points. A second falling edge in the same interval is ignored.
- R9: While `idle_i` is high, a falling edge always produces a hard sync. This holds even where, during a frame, the same edge would have caused a partial shortening of phase segment 2.
- R10: During reset, all strobes are low and `rx_bit_o` is high (recessive).
- R11: `bit_start_o` and `sample_o` are only asserted together with `tq_tick_o`, and they are never asserted on the same tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| brp_i | input | 6 | Prescaler divisor minus one |
| prop_i | input | 4 | Propagation segment length in quanta (1..8) |
| ps1_i | input | 4 | Phase segment 1 length in quanta (1..8) |
| ps2_i | input | 4 | Phase segment 2 length in quanta (2..8) |
| sjw_i | input | 3 | Resynchronization jump width in quanta (1..4, not above either phase segment) |
| rx_i | input | 1 | Raw receive line, 1 = recessive |
| idle_i | input | 1 | High while the bus is idle between frames |
| tq_tick_o | output | 1 | One-clock pulse per time quantum |
| bit_start_o | output | 1 | Bit start strobe, where transmit data may change |
| sample_o | output | 1 | Sample point strobe |
| rx_bit_o | output | 1 | Bus value captured at the last sample point |

## Verification
Falling edges are placed at chosen quantum indices within a bit, and the resulting shifts of the sample point and the bit boundary are checked. An edge in the sync quantum, or a rising edge, must leave the nominal timing in place. Edges at index 1 and index 4 separate an exact stretch from one capped at the jump width. Edges at index 7 and index 6 separate full negative compensation from a shortening capped at the jump width. The same index-6 edge with the idle flag raised must instead produce a hard restart. A double edge within one bit checks that the second edge is dropped. The bit after each correction checks that the nominal lengths come back.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  // kind of timing correction decided on a quantum tick
  typedef enum logic [1:0] {
    SYNC_NONE = 2'd0,
    SYNC_HARD = 2'd1,
    SYNC_POS  = 2'd2,
    SYNC_NEG  = 2'd3
  } sync_kind_t;
endpackage

// File: rtl/can_bt_presc.sv
module can_bt_presc #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt;

  assign tick_o = (cnt >= div_i);

  always_ff @(posedge clk) begin
    if (rst)         cnt <= '0;
    else if (tick_o) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  // R1
  tick_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_o && div_i != '0) |=> (!tick_o || div_i == '0));
endmodule

// File: rtl/can_bt_rxsync.sv
module can_bt_rxsync (
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic rx_i,
  output logic rx_s_o,
  output logic fall_o
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
      prev_q <= 1'b1;
    end else begin
      meta_q <= rx_i;
      sync_q <= meta_q;
      if (tick_i) prev_q <= sync_q;
    end
  end

  assign rx_s_o = sync_q;
  assign fall_o = tick_i & prev_q & ~sync_q;
endmodule

// File: rtl/can_bt_seq.sv
module can_bt_seq
  import can_bt_pkg::*;
#(
  parameter int SEG_W = 4,
  parameter int SJW_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             fall_i,
  input  logic             rx_s_i,
  input  logic             idle_i,
  input  logic [SEG_W-1:0] prop_i,
  input  logic [SEG_W-1:0] ps1_i,
  input  logic [SEG_W-1:0] ps2_i,
  input  logic [SJW_W-1:0] sjw_i,
  output logic             tq_tick_o,
  output logic             bit_start_o,
  output logic             sample_o,
  output logic             rx_bit_o
);
  localparam int PW = SEG_W + 2;

  logic [PW-1:0] pos, t1_end, bit_end;
  logic          synced;
  logic [PW-1:0] t1_nom, end_nom, sjw_x, ext, err, shr_end;
  logic [PW-1:0] pos_n, t1_n, end_n;
  logic          bs, smp, syn_n, wrap;
  sync_kind_t    kind;

  assign t1_nom  = PW'(prop_i) + PW'(ps1_i);
  assign end_nom = t1_nom + PW'(ps2_i);
  assign sjw_x   = PW'(sjw_i);

  always_comb begin
    kind = SYNC_NONE;
    if (fall_i && !synced) begin
      if (idle_i)           kind = SYNC_HARD;
      else if (pos != '0)   kind = (pos > t1_end) ? SYNC_NEG : SYNC_POS;
    end
    ext     = (pos < sjw_x) ? pos : sjw_x;
    err     = bit_end + PW'(1) - pos;
    shr_end = bit_end - sjw_x;
    wrap    = (pos == bit_end);
    pos_n   = wrap ? '0 : pos + PW'(1);
    t1_n    = wrap ? t1_nom : t1_end;
    end_n   = wrap ? end_nom : bit_end;
    bs      = wrap;
    smp     = (pos == t1_end);
    syn_n   = synced & ~smp;
    case (kind)
      SYNC_HARD: begin
        pos_n = PW'(1);
        bs    = 1'b1;
        smp   = 1'b0;
        t1_n  = t1_nom;
        end_n = end_nom;
        syn_n = 1'b1;
      end
      SYNC_POS: begin
        t1_n  = t1_nom + ext;
        end_n = end_nom + ext;
        smp   = 1'b0;
        syn_n = 1'b1;
      end
      SYNC_NEG: begin
        syn_n = 1'b1;
        smp   = 1'b0;
        if (err <= sjw_x) begin
          pos_n = PW'(1);
          bs    = 1'b1;
          t1_n  = t1_nom;
          end_n = end_nom;
        end else if (pos >= shr_end) begin
          pos_n = '0;
          bs    = 1'b1;
          t1_n  = t1_nom;
          end_n = end_nom;
        end else begin
          end_n = shr_end;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pos         <= '0;
      t1_end      <= t1_nom;
      bit_end     <= end_nom;
      synced      <= 1'b0;
      tq_tick_o   <= 1'b0;
      bit_start_o <= 1'b0;
      sample_o    <= 1'b0;
      rx_bit_o    <= 1'b1;
    end else begin
      tq_tick_o   <= tick_i;
      bit_start_o <= tick_i & bs;
      sample_o    <= tick_i & smp;
      if (tick_i) begin
        pos     <= pos_n;
        t1_end  <= t1_n;
        bit_end <= end_n;
        synced  <= syn_n;
        if (smp) rx_bit_o <= rx_s_i;
      end
    end
  end

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(sample_o && bit_start_o));
  // R11
  strobe_tick_chk: assert property (@(posedge clk) disable iff (rst)
    (sample_o || bit_start_o) |-> tq_tick_o);
  // R2
  pos_bound_chk: assert property (@(posedge clk) disable iff (rst)
    pos <= bit_end);
  // R5
  ext_cap_chk: assert property (@(posedge clk) disable iff (rst)
    t1_end <= t1_nom + sjw_x);
  // R8
  one_sync_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_i && fall_i && synced && pos != bit_end) |=> (pos == $past(pos) + PW'(1)));
endmodule

// File: rtl/can_bt_sync.sv
module can_bt_sync #(
  parameter int DIV_W = 6,
  parameter int SEG_W = 4,
  parameter int SJW_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] brp_i,
  input  logic [SEG_W-1:0] prop_i,
  input  logic [SEG_W-1:0] ps1_i,
  input  logic [SEG_W-1:0] ps2_i,
  input  logic [SJW_W-1:0] sjw_i,
  input  logic             rx_i,
  input  logic             idle_i,
  output logic             tq_tick_o,
  output logic             bit_start_o,
  output logic             sample_o,
  output logic             rx_bit_o
);
  logic tick, rx_s, fall;

  can_bt_presc #(.DIV_W(DIV_W)) presc_i (
    .clk(clk), .rst(rst), .div_i(brp_i), .tick_o(tick)
  );

  can_bt_rxsync rxsync_i (
    .clk(clk), .rst(rst), .tick_i(tick), .rx_i(rx_i),
    .rx_s_o(rx_s), .fall_o(fall)
  );

  can_bt_seq #(.SEG_W(SEG_W), .SJW_W(SJW_W)) seq_i (
    .clk(clk), .rst(rst), .tick_i(tick), .fall_i(fall), .rx_s_i(rx_s),
    .idle_i(idle_i), .prop_i(prop_i), .ps1_i(ps1_i), .ps2_i(ps2_i),
    .sjw_i(sjw_i), .tq_tick_o(tq_tick_o), .bit_start_o(bit_start_o),
    .sample_o(sample_o), .rx_bit_o(rx_bit_o)
  );
endmodule

// File: tb/can_bt_sync_tb_top.sv
module can_bt_sync_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] brp = 6'd3;
  logic [3:0] prop = 4'd2, ps1 = 4'd3, ps2 = 4'd3;
  logic [2:0] sjw = 3'd2;
  logic       rx = 1'b1, idle = 1'b0;
  logic       tq_tick_o, bit_start_o, sample_o, rx_bit_o;

  always #5 clk = ~clk;

  can_bt_sync dut_i (
    .clk(clk), .rst(rst), .brp_i(brp), .prop_i(prop), .ps1_i(ps1),
    .ps2_i(ps2), .sjw_i(sjw), .rx_i(rx), .idle_i(idle),
    .tq_tick_o(tq_tick_o), .bit_start_o(bit_start_o),
    .sample_o(sample_o), .rx_bit_o(rx_bit_o)
  );

  typedef struct {
    bit    is_smp;
    int    tick;
    bit    val;
    string req;
  } exp_t;

  exp_t q[$];
  int   tcnt = 0;
  int   total = 0;
  int   bad = 0;
  bit   done = 1'b0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic push(bit s, int t, bit v, string r);
    exp_t e;
    e.is_smp = s; e.tick = t; e.val = v; e.req = r;
    q.push_back(e);
  endtask

  // monitor: pops one expectation per observed strobe
  task automatic take(bit is_smp);
    exp_t e;
    if (q.size() == 0) return;
    e = q.pop_front();
    chk(e.is_smp == is_smp && e.tick == tcnt, e.req,
        is_smp ? "sample tick" : "bit start tick",
        int'(is_smp) * 1000 + tcnt, int'(e.is_smp) * 1000 + e.tick);
    if (is_smp && e.is_smp)
      chk(rx_bit_o == e.val, e.req, "sampled bit", int'(rx_bit_o), int'(e.val));
  endtask

  always @(negedge clk) begin
    if (!rst && tq_tick_o) begin
      tcnt = tcnt + 1;
      if (bit_start_o) take(1'b0);
      if (sample_o)    take(1'b1);
    end
  end

  task automatic wait_bs(output int b);
    do begin
      @(negedge clk); #1;
    end while (!(tq_tick_o && bit_start_o));
    b = tcnt;
  endtask

  task automatic wait_tick(int t);
    while (tcnt < t) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic drain();
    while (q.size() > 0) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic measure(output int n);
    do begin @(negedge clk); #1; end while (!tq_tick_o);
    n = 0;
    do begin @(negedge clk); #1; n++; end while (!tq_tick_o);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  // nominal: T1 = prop+ps1 = 5, bit length N = 9
  initial begin
    int b, n;
    repeat (3) @(negedge clk);
    chk(!tq_tick_o && !bit_start_o && !sample_o && rx_bit_o, "R10",
        "reset outputs", {tq_tick_o, bit_start_o, sample_o, rx_bit_o}, 4'b0001);
    rst = 1'b0;

    // R2 nominal bit
    wait_bs(b);
    push(1, b + 6, 1'b1, "R2");
    push(0, b + 9, 1'b0, "R2");
    drain();

    // R3 edge in sync quantum, then rising edge mid-bit
    wait_bs(b);
    push(1, b + 6, 1'b1, "R3");
    push(0, b + 9, 1'b0, "R3");
    rx = 1'b0;
    wait_tick(b + 3); rx = 1'b1;
    drain();

    // R5 edge at quantum 1, R7 next bit nominal
    wait_bs(b);
    push(1, b + 7, 1'b0, "R5");
    push(0, b + 10, 1'b0, "R5");
    push(1, b + 16, 1'b0, "R7");
    push(0, b + 19, 1'b0, "R7");
    wait_tick(b + 1); rx = 1'b0;
    drain(); rx = 1'b1;

    // R5 edge at quantum 4 capped by jump width 2
    wait_bs(b);
    push(1, b + 8, 1'b0, "R5");
    push(0, b + 11, 1'b0, "R5");
    wait_tick(b + 4); rx = 1'b0;
    drain(); rx = 1'b1;

    // R8 second edge in the same bit ignored
    wait_bs(b);
    push(1, b + 7, 1'b0, "R8");
    push(0, b + 10, 1'b0, "R8");
    wait_tick(b + 1); rx = 1'b0;
    wait_tick(b + 2); rx = 1'b1;
    wait_tick(b + 3); rx = 1'b0;
    drain(); rx = 1'b1;

    // R6 negative error 2 fully compensated
    wait_bs(b);
    push(1, b + 6, 1'b1, "R6");
    push(0, b + 8, 1'b0, "R6");
    push(1, b + 13, 1'b0, "R6");
    push(0, b + 16, 1'b0, "R6");
    wait_tick(b + 7); rx = 1'b0;
    drain(); rx = 1'b1;

    // R6 negative error 3 capped, R7 next bit nominal
    wait_bs(b);
    push(1, b + 6, 1'b1, "R6");
    push(0, b + 7, 1'b0, "R6");
    push(1, b + 13, 1'b0, "R7");
    push(0, b + 16, 1'b0, "R7");
    wait_tick(b + 6); rx = 1'b0;
    drain(); rx = 1'b1;

    // R4 hard sync from idle at quantum 3
    idle = 1'b1;
    wait_bs(b);
    push(0, b + 4, 1'b0, "R4");
    push(1, b + 9, 1'b0, "R4");
    push(0, b + 12, 1'b0, "R4");
    wait_tick(b + 3); rx = 1'b0;
    drain(); rx = 1'b1;

    // R9 idle edge at quantum 6 restarts fully
    wait_bs(b);
    push(1, b + 6, 1'b1, "R9");
    push(0, b + 7, 1'b0, "R9");
    push(1, b + 12, 1'b0, "R9");
    push(0, b + 15, 1'b0, "R9");
    wait_tick(b + 6); rx = 1'b0;
    drain(); rx = 1'b1;
    idle = 1'b0;

    // R1 prescaler periods
    measure(n);
    chk(n == 4, "R1", "tick period brp=3", n, 4);
    brp = 6'd5;
    measure(n);
    measure(n);
    chk(n == 6, "R1", "tick period brp=5", n, 6);

    finish_run();
  end
endmodule